// File: doc/BRIEF.md
# Run-Time Associativity Tile Cluster Address Network

This block joins a power-of-two number of identical cache tiles into one cache memory whose associativity can be changed while the system runs. A lookup request carries a set address, a tag, an associativity exponent and a count of active ways. All of these are captured together in one register stage. The set address is cut into a row index, which is fixed and is sent to every tile, and a tile index, which picks one tile inside a way.

A tree of steering stages, one stage per tile-index bit, routes the access. The stage nearest the root uses the most significant tile-index bit. When the associativity exponent is `a`, the top `a` stages broadcast to both subtrees and the stages below them steer. Each stage always reads the same address bit, so raising the associativity only removes tile-index bits from the top. Ways are numbered from the upper tile-index bits. Any count of active ways is allowed, and the ways with the highest numbers are switched off first.

The hit, valid and dirty flags that the tiles return are masked by the tile enables. They are then merged into a hit flag, the tile and way that hit, the read data, per-way flag vectors and a multi-hit error flag. This whole path is combinational from the registered request.

Top module: `tile_cluster_net`

## Requirements
- R1: While rst_ni is low, lookup_valid_o is 0, tile_en_o is all zero and hit_o is 0.
- R2: A request sampled with req_valid_i high at a rising clock edge gives lookup_valid_o = 1 after that edge, row_o = set_i[ROW_W-1:0] and tag_o = tag_i. An edge with req_valid_i low gives lookup_valid_o = 0 and tile_en_o = 0, and row_o and tag_o hold their previous values.
- R3: With associativity exponent 0 and at least one active way, exactly one tile is enabled. Its index is the tile field set_i[ROW_W +: TILE_W].
- R4: With exponent a, tile t is steered in when its tile-index bits below bit TILE_W-a equal the matching bits of the tile field. Stage s of the tree always compares tile-index bit TILE_W-1-s, and stages s < a broadcast.
- R5: The way number of tile t is t >> (TILE_W-a). Tiles whose way number is not below ways_i are disabled. ways_i = 0 disables every tile, and ways_i >= 2^a enables every way.
- R6: way_hit_o, way_valid_o and way_dirty_o hold, at bit position w, the hit, valid and dirty flag of the enabled tile of way w. Inputs from tiles that are not enabled have no effect on any output, and bits at way numbers with no enabled tile read 0.
- R7: hit_o is 1 when any enabled tile hits. hit_tile_o is the lowest enabled hitting tile index, hit_way_o is its way number, and rdata_o is its data slice tile_data_i[t*DATA_W +: DATA_W]. On a miss, rdata_o, hit_tile_o and hit_way_o are 0.
- R8: multi_hit_o is 1 exactly when two or more enabled tiles report a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Capture a lookup request |
| set_i | input | SET_W (7) | Set address: row field low, tile field high |
| tag_i | input | TAG_W (8) | Tag for the shared tile bus |
| assoc_i | input | AW (2) | Associativity exponent |
| ways_i | input | CW (4) | Number of active ways |
| tile_hit_i | input | N_TILES (8) | Per-tile tag match |
| tile_valid_i | input | N_TILES (8) | Per-tile line valid flag |
| tile_dirty_i | input | N_TILES (8) | Per-tile line dirty flag |
| tile_data_i | input | N_TILES*DATA_W (128) | Per-tile read data, tile t at slice t |
| lookup_valid_o | output | 1 | Registered request is live |
| tile_en_o | output | N_TILES (8) | Per-tile enable |
| row_o | output | ROW_W (4) | Row index on the shared bus |
| tag_o | output | TAG_W (8) | Tag on the shared bus |
| hit_o | output | 1 | Some enabled tile hit |
| hit_tile_o | output | TILE_W (3) | Index of the winning tile |
| hit_way_o | output | TILE_W (3) | Way of the winning tile |
| rdata_o | output | DATA_W (16) | Data of the winning tile |
| multi_hit_o | output | 1 | More than one enabled tile hit |
| way_hit_o | output | N_TILES (8) | Hit flag per way |
| way_valid_o | output | N_TILES (8) | Valid flag per way |
| way_dirty_o | output | N_TILES (8) | Dirty flag per way |

## Verification
The stimulus drives hit, valid and dirty on tiles that are not enabled. A network that gated late would then leak a foreign hit or data word into the outputs. Way counts that are not powers of two, and a way count of zero, check that ways are cut from the top. A reversed comparison would switch off way 0 instead, or enable everything. Full broadcast with several hits checks the lowest-index priority and the multi-hit flag, which a wrong priority encoder would point at the highest hitting tile. Sweeping the exponent against a fixed set address checks that each tree stage keeps its own address bit, which a design that realigned the tile field would break by enabling the wrong tile.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {
    STAGE_STEER = 1'b0,
    STAGE_BCAST = 1'b1
  } stage_mode_e;

  // way number of a tile under a given associativity exponent
  function automatic int unsigned way_of(int unsigned tile, int unsigned assoc,
                                         int unsigned tile_w);
    return tile >> (tile_w - assoc);
  endfunction
endpackage

// File: rtl/tc_req_reg.sv
module tc_req_reg #(
  parameter int ROW_W  = 4,
  parameter int TILE_W = 3,
  parameter int TAG_W  = 8,
  parameter int AW     = 2,
  parameter int CW     = 4,
  localparam int SET_W = ROW_W + TILE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [AW-1:0]     assoc_i,
  input  logic [CW-1:0]     ways_i,
  output logic              valid_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [TILE_W-1:0] tile_addr_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [AW-1:0]     assoc_o,
  output logic [CW-1:0]     ways_o
);
  logic [AW-1:0] assoc_clip;

  assign assoc_clip = (assoc_i > AW'(TILE_W)) ? AW'(TILE_W) : assoc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      row_o       <= '0;
      tile_addr_o <= '0;
      tag_o       <= '0;
      assoc_o     <= '0;
      ways_o      <= '0;
    end else begin
      valid_o <= req_valid_i;
      if (req_valid_i) begin
        row_o       <= set_i[ROW_W-1:0];
        tile_addr_o <= set_i[SET_W-1:ROW_W];
        tag_o       <= tag_i;
        assoc_o     <= assoc_clip;
        ways_o      <= ways_i;
      end
    end
  end
endmodule

// File: rtl/tc_steer_tree.sv
module tc_steer_tree
  import tc_pkg::*;
#(
  parameter int TILE_W  = 3,
  parameter int AW      = 2,
  localparam int N_TILES = 1 << TILE_W
) (
  input  logic               valid_i,
  input  logic [TILE_W-1:0]  tile_addr_i,
  input  logic [AW-1:0]      assoc_i,
  output logic [N_TILES-1:0] en_o
);
  stage_mode_e mode [TILE_W];

  // stage s always reads tile-address bit TILE_W-1-s; upper stages broadcast
  for (genvar s = 0; s < TILE_W; s++) begin : g_stage
    assign mode[s] = (AW'(s) < assoc_i) ? STAGE_BCAST : STAGE_STEER;
  end

  for (genvar t = 0; t < N_TILES; t++) begin : g_leaf
    logic [TILE_W-1:0] pass;
    for (genvar s = 0; s < TILE_W; s++) begin : g_path
      localparam int B = TILE_W - 1 - s;
      localparam logic DIR = 1'((t >> B) & 1);
      assign pass[s] = (mode[s] == STAGE_BCAST) || (tile_addr_i[B] == DIR);
    end
    assign en_o[t] = valid_i & (&pass);
  end
endmodule

// File: rtl/tc_way_mask.sv
module tc_way_mask
  import tc_pkg::*;
#(
  parameter int TILE_W  = 3,
  parameter int AW      = 2,
  parameter int CW      = 4,
  localparam int N_TILES = 1 << TILE_W
) (
  input  logic [AW-1:0]      assoc_i,
  input  logic [CW-1:0]      ways_i,
  output logic [N_TILES-1:0] live_o
);
  for (genvar t = 0; t < N_TILES; t++) begin : g_tile
    logic [CW-1:0] wid;
    assign wid       = CW'(way_of(t, int'(assoc_i), TILE_W));
    assign live_o[t] = wid < ways_i;
  end
endmodule

// File: rtl/tc_hit_merge.sv
module tc_hit_merge
  import tc_pkg::*;
#(
  parameter int TILE_W  = 3,
  parameter int AW      = 2,
  parameter int DATA_W  = 16,
  localparam int N_TILES = 1 << TILE_W
) (
  input  logic [N_TILES-1:0]        en_i,
  input  logic [AW-1:0]             assoc_i,
  input  logic [N_TILES-1:0]        hit_i,
  input  logic [N_TILES-1:0]        valid_i,
  input  logic [N_TILES-1:0]        dirty_i,
  input  logic [N_TILES*DATA_W-1:0] data_i,
  output logic                      hit_o,
  output logic [TILE_W-1:0]         hit_tile_o,
  output logic [TILE_W-1:0]         hit_way_o,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      multi_hit_o,
  output logic [N_TILES-1:0]        way_hit_o,
  output logic [N_TILES-1:0]        way_valid_o,
  output logic [N_TILES-1:0]        way_dirty_o
);
  logic [N_TILES-1:0] hit_m, val_m, dty_m;
  logic [TILE_W-1:0]  win;

  assign hit_m = hit_i & en_i;
  assign val_m = valid_i & en_i;
  assign dty_m = dirty_i & en_i;

  always_comb begin
    win = '0;
    for (int t = N_TILES - 1; t >= 0; t--) begin
      if (hit_m[t]) win = TILE_W'(t);
    end
  end

  always_comb begin
    way_hit_o   = '0;
    way_valid_o = '0;
    way_dirty_o = '0;
    for (int t = 0; t < N_TILES; t++) begin
      if (en_i[t]) begin
        way_hit_o[way_of(t, int'(assoc_i), TILE_W)]   = hit_m[t];
        way_valid_o[way_of(t, int'(assoc_i), TILE_W)] = val_m[t];
        way_dirty_o[way_of(t, int'(assoc_i), TILE_W)] = dty_m[t];
      end
    end
  end

  assign hit_o       = |hit_m;
  assign multi_hit_o = $countones(hit_m) > 1;
  assign hit_tile_o  = hit_o ? win : '0;
  assign hit_way_o   = hit_o ? TILE_W'(way_of(int'(win), int'(assoc_i), TILE_W)) : '0;
  assign rdata_o     = hit_o ? data_i[win*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/tile_cluster_net.sv
module tile_cluster_net #(
  parameter int TILE_W  = 3,
  parameter int ROW_W   = 4,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 16,
  localparam int N_TILES = 1 << TILE_W,
  localparam int SET_W   = ROW_W + TILE_W,
  localparam int AW      = $clog2(TILE_W + 1),
  localparam int CW      = TILE_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [SET_W-1:0]          set_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic [AW-1:0]             assoc_i,
  input  logic [CW-1:0]             ways_i,
  input  logic [N_TILES-1:0]        tile_hit_i,
  input  logic [N_TILES-1:0]        tile_valid_i,
  input  logic [N_TILES-1:0]        tile_dirty_i,
  input  logic [N_TILES*DATA_W-1:0] tile_data_i,
  output logic                      lookup_valid_o,
  output logic [N_TILES-1:0]        tile_en_o,
  output logic [ROW_W-1:0]          row_o,
  output logic [TAG_W-1:0]          tag_o,
  output logic                      hit_o,
  output logic [TILE_W-1:0]         hit_tile_o,
  output logic [TILE_W-1:0]         hit_way_o,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      multi_hit_o,
  output logic [N_TILES-1:0]        way_hit_o,
  output logic [N_TILES-1:0]        way_valid_o,
  output logic [N_TILES-1:0]        way_dirty_o
);
  logic [TILE_W-1:0]  tile_addr_q;
  logic [AW-1:0]      assoc_q;
  logic [CW-1:0]      ways_q;
  logic [N_TILES-1:0] steer_en, live;

  tc_req_reg #(
    .ROW_W(ROW_W), .TILE_W(TILE_W), .TAG_W(TAG_W), .AW(AW), .CW(CW)
  ) u_req (
    .clk_i, .rst_ni, .req_valid_i, .set_i, .tag_i, .assoc_i, .ways_i,
    .valid_o(lookup_valid_o), .row_o, .tile_addr_o(tile_addr_q),
    .tag_o, .assoc_o(assoc_q), .ways_o(ways_q)
  );

  tc_steer_tree #(.TILE_W(TILE_W), .AW(AW)) u_tree (
    .valid_i(lookup_valid_o), .tile_addr_i(tile_addr_q), .assoc_i(assoc_q),
    .en_o(steer_en)
  );

  tc_way_mask #(.TILE_W(TILE_W), .AW(AW), .CW(CW)) u_ways (
    .assoc_i(assoc_q), .ways_i(ways_q), .live_o(live)
  );

  assign tile_en_o = steer_en & live;

  tc_hit_merge #(.TILE_W(TILE_W), .AW(AW), .DATA_W(DATA_W)) u_merge (
    .en_i(tile_en_o), .assoc_i(assoc_q), .hit_i(tile_hit_i),
    .valid_i(tile_valid_i), .dirty_i(tile_dirty_i), .data_i(tile_data_i),
    .hit_o, .hit_tile_o, .hit_way_o, .rdata_o, .multi_hit_o,
    .way_hit_o, .way_valid_o, .way_dirty_o
  );
endmodule

// File: rtl/tc_net_chk.sv
module tc_net_chk #(
  parameter int TILE_W  = 3,
  parameter int ROW_W   = 4,
  parameter int DATA_W  = 16,
  localparam int N_TILES = 1 << TILE_W,
  localparam int SET_W   = ROW_W + TILE_W,
  localparam int AW      = $clog2(TILE_W + 1),
  localparam int CW      = TILE_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [SET_W-1:0]   set_i,
  input logic [AW-1:0]      assoc_i,
  input logic [CW-1:0]      ways_i,
  input logic [N_TILES-1:0] tile_hit_i,
  input logic               lookup_valid_o,
  input logic [N_TILES-1:0] tile_en_o,
  input logic [ROW_W-1:0]   row_o,
  input logic               hit_o,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               multi_hit_o,
  input logic [N_TILES-1:0] way_hit_o
);
  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!lookup_valid_o && tile_en_o == '0 && !hit_o);
    end
  end

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> lookup_valid_o && row_o == $past(set_i[ROW_W-1:0]));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !lookup_valid_o && tile_en_o == '0 && $stable(row_o));

  p_direct_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && assoc_i == '0 && ways_i != '0) |=>
      tile_en_o == (N_TILES'(1) << $past(set_i[SET_W-1:ROW_W])));

  p_no_ways_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ways_i == '0) |=> tile_en_o == '0);

  p_way_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|way_hit_o) == hit_o);

  p_miss_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> rdata_o == '0);

  p_multi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o == ($countones(tile_hit_i & tile_en_o) > 1));
endmodule

bind tile_cluster_net tc_net_chk #(
  .TILE_W(TILE_W), .ROW_W(ROW_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_tile_cluster_net.sv
`timescale 1ns/1ps
module sim_tile_cluster_net;
  localparam int TW = 3, N = 8, RW = 4, TGW = 8, DW = 16;
  localparam int SW = RW + TW, AW = 2, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [SW-1:0] set_a = '0;
  logic [TGW-1:0] tag = '0;
  logic [AW-1:0] asc = '0;
  logic [CW-1:0] ways = '0;
  logic [N-1:0] t_hit = '0, t_val = '0, t_dty = '0;
  logic [N*DW-1:0] t_dat = '0;
  logic lv, hit, multi;
  logic [N-1:0] en, whit, wval, wdty;
  logic [RW-1:0] row;
  logic [TGW-1:0] tag_q;
  logic [TW-1:0] htile, hway;
  logic [DW-1:0] rdata;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  tile_cluster_net #(.TILE_W(TW), .ROW_W(RW), .TAG_W(TGW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .set_i(set_a), .tag_i(tag),
    .assoc_i(asc), .ways_i(ways), .tile_hit_i(t_hit), .tile_valid_i(t_val),
    .tile_dirty_i(t_dty), .tile_data_i(t_dat), .lookup_valid_o(lv),
    .tile_en_o(en), .row_o(row), .tag_o(tag_q), .hit_o(hit),
    .hit_tile_o(htile), .hit_way_o(hway), .rdata_o(rdata),
    .multi_hit_o(multi), .way_hit_o(whit), .way_valid_o(wval), .way_dirty_o(wdty)
  );

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [N-1:0] exp_en(logic [SW-1:0] s, int a, int w);
    logic [N-1:0] r = '0;
    int sh = TW - a;
    int tf = int'(s[SW-1:RW]);
    for (int t = 0; t < N; t++)
      if ((((t ^ tf) & ((1 << sh) - 1)) == 0) && ((t >> sh) < w)) r[t] = 1'b1;
    return r;
  endfunction

  task automatic lookup(logic [SW-1:0] s, logic [TGW-1:0] g, int a, int w,
                        logic [N-1:0] h, logic [N-1:0] v, logic [N-1:0] d);
    logic [N-1:0] e, m, ewh, ewv, ewd;
    int sh, win;
    @(negedge clk);
    req = 1'b1; set_a = s; tag = g; asc = AW'(a); ways = CW'(w);
    @(negedge clk);
    req = 1'b0;
    t_hit = h; t_val = v; t_dty = d;
    t_dat = {$urandom, $urandom, $urandom, $urandom};
    #1;
    e = exp_en(s, a, w);
    sh = TW - a;
    m = h & e;
    win = 0;
    for (int t = N - 1; t >= 0; t--) if (m[t]) win = t;
    ewh = '0; ewv = '0; ewd = '0;
    for (int t = 0; t < N; t++)
      if (e[t]) begin
        ewh[t >> sh] = h[t]; ewv[t >> sh] = v[t]; ewd[t >> sh] = d[t];
      end
    chk("R2 lookup_valid", 64'(lv), 64'(1));
    chk("R2 row", 64'(row), 64'(s[RW-1:0]));
    chk("R2 tag", 64'(tag_q), 64'(g));
    chk(a == 0 ? "R3 tile_en" : "R4/R5 tile_en", 64'(en), 64'(e));
    chk("R6 way_hit", 64'(whit), 64'(ewh));
    chk("R6 way_valid", 64'(wval), 64'(ewv));
    chk("R6 way_dirty", 64'(wdty), 64'(ewd));
    chk("R7 hit", 64'(hit), 64'(m != '0));
    chk("R7 hit_tile", 64'(htile), m != '0 ? 64'(win) : 64'(0));
    chk("R7 hit_way", 64'(hway), m != '0 ? 64'(win >> sh) : 64'(0));
    chk("R7 rdata", 64'(rdata), m != '0 ? 64'(t_dat[win*DW +: DW]) : 64'(0));
    chk("R8 multi_hit", 64'(multi), 64'($countones(m) > 1));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1d5e_a11c));
    #7;
    chk("R1 lookup_valid in reset", 64'(lv), 64'(0));
    chk("R1 tile_en in reset", 64'(en), 64'(0));
    chk("R1 hit in reset", 64'(hit), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // R3 direct mapped, single way
    lookup(7'b101_0110, 8'h3c, 0, 1, 8'hff, 8'hff, 8'h0f);
    // R4 full broadcast, multi-hit with lowest priority (R8)
    lookup(7'b010_0001, 8'h11, 3, 8, 8'b0010_0100, 8'h5a, 8'ha5);
    // R5 non-power-of-two way count
    lookup(7'b000_1111, 8'h22, 3, 5, 8'b1110_0000, 8'hff, 8'hff);
    lookup(7'b110_0011, 8'h33, 2, 3, 8'hff, 8'h0f, 8'hf0);
    // R5 zero ways
    lookup(7'b011_0000, 8'h44, 2, 0, 8'hff, 8'hff, 8'hff);
    // R4 exponent sweep at a fixed set address
    for (int a = 0; a <= TW; a++) lookup(7'b011_1010, 8'h55, a, 8, 8'b0100_1000, 8'hc3, 8'h3c);
    // R6 hits only on disabled tiles
    lookup(7'b001_0101, 8'h66, 1, 1, 8'b1111_1101, 8'hfd, 8'hfd);

    // R2 hold: a cycle with no request keeps row and tag, enables drop
    @(negedge clk);
    req = 1'b0; set_a = 7'b111_1111; tag = 8'hee;
    @(negedge clk);
    #1;
    chk("R2 idle lookup_valid", 64'(lv), 64'(0));
    chk("R2 idle tile_en", 64'(en), 64'(0));
    chk("R2 idle row held", 64'(row), 64'(4'b0101));
    chk("R2 idle tag held", 64'(tag_q), 64'(8'h66));
    chk("R7 idle no hit", 64'(hit), 64'(0));

    for (int i = 0; i < 400; i++) begin
      lookup(SW'($urandom), TGW'($urandom), int'($urandom_range(0, TW)),
             int'($urandom_range(0, N)), N'($urandom), N'($urandom), N'($urandom));
    end
    summary();
  end
endmodule